// File: doc/BRIEF.md
# Chaining-Value Register with Mode-Dependent Writeback

This block holds the 128-bit initialisation vector of a block-cipher engine and updates it after every processed block. When the cipher datapath signals that a block is finished, the block chooses the next chaining value from the selected mode and direction. It takes either the data that went into the block, the result that came out, or the current vector advanced by a big-endian counter that is confined to a selectable low-order field.

The host can read the vector at all times and can write it. A write made while no block is in flight takes effect at once. A write made while a block is in flight is held back and replaces the chaining value when that block completes. A zeroize strobe wipes the vector and any held write. The cipher itself lies outside this block.

Top module: `iv_chain_unit`

## Requirements
- R1: After reset `iv_o` is all zeros and no block is in flight.
- R2: A `zeroize_i` pulse clears `iv_o` to zero in the next cycle and discards any held host write. It takes priority over every other update.
- R3: A host write (`host_wr_i`) while no block is in flight appears on `iv_o` one cycle later.
- R4: A host write while a block is in flight (between `blk_start_i` and `blk_done_i`) leaves `iv_o` unchanged until the block completes. In the completion cycle the last host write replaces the chaining value. A host write in the completion cycle itself also wins over the chaining value.
- R5: Mode code 1 (CBC) and mode code 2 (CFB-128): after a block the IV holds the ciphertext. That is `blk_res_i` when `encrypt_i`=1 and `blk_in_i` when `encrypt_i`=0.
- R6: Mode code 0 (ECB): after a block the IV holds `blk_res_i` in both directions. This is the ciphertext when encrypting and the plaintext when decrypting.
- R7: Mode code 3 (counter): after a block the IV is incremented by one as a big-endian number. The increment is confined to the low-order field chosen by `ctr_size_i`: 0 = 32 bits, 1 = 64, 2 = 96, 3 = 128, 4 = 16, and codes 5 to 7 select 32. The field wraps to zero, and all bits above it are unchanged.
- R8: With `ctr_size_i`=3 the counter spans the whole vector, so all ones is followed by all zeros.
- R9: Mode code 4 (f8) advances the IV with the same increment and counter-field rule as R7.
- R10: Mode codes 5 to 7 leave the IV unchanged when a block completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zeroize_i | input | 1 | Wipe vector and held write |
| mode_i | input | 3 | Chaining mode code |
| encrypt_i | input | 1 | 1 = encrypt, 0 = decrypt |
| ctr_size_i | input | 3 | Counter field width code |
| blk_start_i | input | 1 | A block enters the cipher |
| blk_done_i | input | 1 | The block in flight has finished |
| blk_in_i | input | 128 | Data submitted for the block |
| blk_res_i | input | 128 | Data produced for the block |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 128 | Host write value |
| iv_o | output | 128 | Current vector (host read) |

## Verification
Every update of `iv_o` is due one clock edge after the strobe that causes it. The bench drives strobes on a falling edge, drops them on the next falling edge and samples `iv_o` there, half a cycle after the rising edge that loaded it. For a held host write, the bench samples after the write strobe while the block is still in flight, to see that `iv_o` has not moved. It then samples again one edge after `blk_done_i`. Expected chaining values are derived in the bench with a byte-wise carry loop over the big-endian vector.

// File: rtl/iv_chain_pkg.sv
`timescale 1ns/1ps
package iv_chain_pkg;

  typedef enum logic [2:0] {
    MODE_ECB = 3'd0,
    MODE_CBC = 3'd1,
    MODE_CFB = 3'd2,
    MODE_CTR = 3'd3,
    MODE_F8  = 3'd4
  } chain_mode_e;

  typedef enum logic [2:0] {
    CSZ_32  = 3'd0,
    CSZ_64  = 3'd1,
    CSZ_96  = 3'd2,
    CSZ_128 = 3'd3,
    CSZ_16  = 3'd4
  } ctr_size_e;

  // Width in bits of the counter field for a size code; unused codes act as 32.
  function automatic int unsigned ctr_field_bits(input logic [2:0] code);
    case (code)
      CSZ_64:  return 64;
      CSZ_96:  return 96;
      CSZ_128: return 128;
      CSZ_16:  return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/iv_next_calc.sv
`timescale 1ns/1ps
module iv_next_calc
  import iv_chain_pkg::*;
#(
  parameter int unsigned IV_W = 128
) (
  input  logic [IV_W-1:0] iv_i,
  input  logic [2:0]      mode_i,
  input  logic            encrypt_i,
  input  logic [2:0]      ctr_size_i,
  input  logic [IV_W-1:0] blk_in_i,
  input  logic [IV_W-1:0] blk_res_i,
  output logic [IV_W-1:0] next_o
);

  // Mask of the low-order counter field, clamped to the vector width.
  function automatic logic [IV_W-1:0] field_mask(input logic [2:0] code);
    int unsigned nb;
    nb = ctr_field_bits(code);
    if (nb > IV_W) nb = IV_W;
    return {IV_W{1'b1}} >> (IV_W - nb);
  endfunction

  // Big-endian +1 whose carry stops at the top of the field.
  function automatic logic [IV_W-1:0] field_incr(input logic [IV_W-1:0] v,
                                                 input logic [IV_W-1:0] m);
    return (v & ~m) | ((v + IV_W'(1)) & m);
  endfunction

  logic [IV_W-1:0] ctr_mask;
  logic [IV_W-1:0] ctr_next;
  logic [IV_W-1:0] cipher_text;

  assign ctr_mask    = field_mask(ctr_size_i);
  assign ctr_next    = field_incr(iv_i, ctr_mask);
  assign cipher_text = encrypt_i ? blk_res_i : blk_in_i;

  always_comb begin
    case (chain_mode_e'(mode_i))
      MODE_ECB:         next_o = blk_res_i;
      MODE_CBC,
      MODE_CFB:         next_o = cipher_text;
      MODE_CTR,
      MODE_F8:          next_o = ctr_next;
      default:          next_o = iv_i;
    endcase
  end

endmodule

// File: rtl/iv_host_hold.sv
`timescale 1ns/1ps
module iv_host_hold #(
  parameter int unsigned IV_W = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            zeroize_i,
  input  logic            blk_start_i,
  input  logic            blk_done_i,
  input  logic            host_wr_i,
  input  logic [IV_W-1:0] host_wdata_i,
  output logic            busy_o,
  output logic            hold_vld_o,
  output logic [IV_W-1:0] hold_data_o
);

  logic            busy_q;
  logic            hold_q;
  logic [IV_W-1:0] hold_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      hold_q      <= 1'b0;
      hold_data_q <= '0;
    end else begin
      busy_q <= blk_start_i | (busy_q & ~blk_done_i);
      if (zeroize_i || blk_done_i) begin
        hold_q      <= 1'b0;
        hold_data_q <= '0;
      end else if (host_wr_i && busy_q) begin
        hold_q      <= 1'b1;
        hold_data_q <= host_wdata_i;
      end
    end
  end

  assign busy_o      = busy_q;
  assign hold_vld_o  = hold_q;
  assign hold_data_o = hold_data_q;

endmodule

// File: rtl/iv_chain_unit.sv
`timescale 1ns/1ps
module iv_chain_unit #(
  parameter int unsigned IV_W = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            zeroize_i,
  input  logic [2:0]      mode_i,
  input  logic            encrypt_i,
  input  logic [2:0]      ctr_size_i,
  input  logic            blk_start_i,
  input  logic            blk_done_i,
  input  logic [IV_W-1:0] blk_in_i,
  input  logic [IV_W-1:0] blk_res_i,
  input  logic            host_wr_i,
  input  logic [IV_W-1:0] host_wdata_i,
  output logic [IV_W-1:0] iv_o
);

  logic [IV_W-1:0] iv_q;
  logic [IV_W-1:0] chain_next;
  logic            busy;
  logic            hold_vld;
  logic [IV_W-1:0] hold_data;

  // Named events for the checker.
  logic host_now;    // host write lands this edge
  logic hold_land;   // held write lands this edge
  logic chain_land;  // chaining value lands this edge

  iv_next_calc #(.IV_W(IV_W)) calc_i (
    .iv_i       (iv_q),
    .mode_i     (mode_i),
    .encrypt_i  (encrypt_i),
    .ctr_size_i (ctr_size_i),
    .blk_in_i   (blk_in_i),
    .blk_res_i  (blk_res_i),
    .next_o     (chain_next)
  );

  iv_host_hold #(.IV_W(IV_W)) hold_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .zeroize_i    (zeroize_i),
    .blk_start_i  (blk_start_i),
    .blk_done_i   (blk_done_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .busy_o       (busy),
    .hold_vld_o   (hold_vld),
    .hold_data_o  (hold_data)
  );

  assign host_now   = ~zeroize_i & host_wr_i & (~busy | blk_done_i);
  assign hold_land  = ~zeroize_i & ~host_now & blk_done_i & hold_vld;
  assign chain_land = ~zeroize_i & ~host_now & blk_done_i & ~hold_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          iv_q <= '0;
    else if (zeroize_i)  iv_q <= '0;
    else if (host_now)   iv_q <= host_wdata_i;
    else if (hold_land)  iv_q <= hold_data;
    else if (chain_land) iv_q <= chain_next;
  end

  assign iv_o = iv_q;

endmodule

// File: rtl/iv_chain_checker.sv
`timescale 1ns/1ps
module iv_chain_checker #(
  parameter int unsigned IV_W = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            zeroize_i,
  input logic [2:0]      mode_i,
  input logic            encrypt_i,
  input logic [2:0]      ctr_size_i,
  input logic            blk_done_i,
  input logic [IV_W-1:0] blk_res_i,
  input logic            host_wr_i,
  input logic [IV_W-1:0] host_wdata_i,
  input logic [IV_W-1:0] iv_o,
  input logic            busy,
  input logic            hold_vld
);

  logic clean_done;
  assign clean_done = blk_done_i & ~zeroize_i & ~host_wr_i & ~hold_vld;

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (iv_o == '0 && !busy));

  assert_zeroize_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    zeroize_i |=> (iv_o == '0 && !hold_vld));

  assert_idle_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_i && !zeroize_i && !busy) |=> iv_o == $past(host_wdata_i));

  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk_done_i && !zeroize_i) |=> $stable(iv_o));

  assert_cbc_enc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_done && mode_i == 3'd1 && encrypt_i) |=> iv_o == $past(blk_res_i));

  assert_ecb_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_done && mode_i == 3'd0) |=> iv_o == $past(blk_res_i));

  assert_ctr32_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_done && mode_i == 3'd3 && ctr_size_i == 3'd0) |=>
      (iv_o[IV_W-1:32] == $past(iv_o[IV_W-1:32]) &&
       iv_o[31:0] == $past(iv_o[31:0]) + 32'd1));

  assert_unused_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_done && mode_i > 3'd4) |=> $stable(iv_o));

endmodule

bind iv_chain_unit iv_chain_checker #(.IV_W(IV_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .zeroize_i    (zeroize_i),
  .mode_i       (mode_i),
  .encrypt_i    (encrypt_i),
  .ctr_size_i   (ctr_size_i),
  .blk_done_i   (blk_done_i),
  .blk_res_i    (blk_res_i),
  .host_wr_i    (host_wr_i),
  .host_wdata_i (host_wdata_i),
  .iv_o         (iv_o),
  .busy         (busy),
  .hold_vld     (hold_vld)
);

// File: tb/iv_chain_unit_tb.sv
`timescale 1ns/1ps
module iv_chain_unit_tb_top;

  localparam int NV = 15;

  // Table: mode, direction, counter size code, starting vector.
  localparam logic [2:0] V_MODE [NV] = '{3'd1, 3'd1, 3'd2, 3'd2, 3'd0, 3'd0,
                                         3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd4,
                                         3'd4, 3'd6, 3'd3};
  localparam logic       V_ENC  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                         1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                                         1'b0, 1'b1, 1'b1};
  localparam logic [2:0] V_SIZE [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0,
                                         3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0,
                                         3'd4, 3'd0, 3'd7};
  localparam logic [127:0] V_IV [NV] = '{
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'h1111_2222_3333_4444_5555_6666_ffff_ffff,
    128'h1111_2222_3333_4444_00ff_ffff_ffff_ffff,
    128'h7777_8888_ffff_ffff_ffff_ffff_ffff_ffff,
    128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff,
    128'haaaa_bbbb_cccc_dddd_eeee_ffff_1234_ffff,
    128'h0000_0000_0000_0000_0000_0000_0000_00ff,
    128'h5555_5555_5555_5555_5555_5555_9999_ffff,
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'hcccc_cccc_cccc_cccc_cccc_cccc_ffff_ffff};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         zeroize = 1'b0;
  logic [2:0]   mode = 3'd0;
  logic         enc = 1'b0;
  logic [2:0]   csize = 3'd0;
  logic         start = 1'b0;
  logic         done = 1'b0;
  logic [127:0] bin = '0;
  logic [127:0] bres = '0;
  logic         hwr = 1'b0;
  logic [127:0] hdata = '0;
  logic [127:0] iv;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  iv_chain_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .zeroize_i    (zeroize),
    .mode_i       (mode),
    .encrypt_i    (enc),
    .ctr_size_i   (csize),
    .blk_start_i  (start),
    .blk_done_i   (done),
    .blk_in_i     (bin),
    .blk_res_i    (bres),
    .host_wr_i    (hwr),
    .host_wdata_i (hdata),
    .iv_o         (iv)
  );

  // Byte-wise big-endian increment over the last nbytes bytes.
  function automatic logic [127:0] ref_bump(input logic [127:0] v, input int nbytes);
    logic [127:0] r;
    logic [8:0]   s;
    logic         c;
    r = v;
    c = 1'b1;
    for (int b = 0; b < nbytes; b++) begin
      s = {1'b0, r[8*b +: 8]} + {8'd0, c};
      r[8*b +: 8] = s[7:0];
      c = s[8];
    end
    return r;
  endfunction

  function automatic int ref_bytes(input logic [2:0] code);
    case (code)
      3'd1: return 8;
      3'd2: return 12;
      3'd3: return 16;
      3'd4: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [127:0] ref_next(input logic [2:0] m, input logic e,
      input logic [2:0] sz, input logic [127:0] v, input logic [127:0] di,
      input logic [127:0] dr);
    case (m)
      3'd0: return dr;
      3'd1, 3'd2: return e ? dr : di;
      3'd3, 3'd4: return ref_bump(v, ref_bytes(sz));
      default: return v;
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] exp);
    n_run++;
    if (iv !== exp) begin
      n_fail++;
      $display("FAIL %s: iv_o=%h expected=%h", req, iv, exp);
    end
  endtask

  task automatic host_load(input logic [127:0] v);
    @(negedge clk); hwr = 1'b1; hdata = v;
    @(negedge clk); hwr = 1'b0;
  endtask

  task automatic blk_begin();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic blk_end(input logic [127:0] di, input logic [127:0] dr);
    @(negedge clk); done = 1'b1; bin = di; bres = dr;
    @(negedge clk); done = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] di, dr, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0);

    // Table walk: R3 on load, then the mode-dependent writeback (R5..R10).
    for (int k = 0; k < NV; k++) begin
      di = {16{8'(8'h10 + k)}};
      dr = {16{8'(8'h80 + k)}};
      mode = V_MODE[k]; enc = V_ENC[k]; csize = V_SIZE[k];
      host_load(V_IV[k]);
      check("R3", V_IV[k]);
      blk_begin();
      blk_end(di, dr);
      exp = ref_next(V_MODE[k], V_ENC[k], V_SIZE[k], V_IV[k], di, dr);
      case (V_MODE[k])
        3'd0:       check("R6", exp);
        3'd1, 3'd2: check("R5", exp);
        3'd3:       check((V_SIZE[k] == 3'd3) ? "R8" : "R7", exp);
        3'd4:       check("R9", exp);
        default:    check("R10", exp);
      endcase
    end

    // R2: zeroize wipes the vector.
    host_load(128'hdead_beef_0000_1111_2222_3333_4444_5555);
    @(negedge clk); zeroize = 1'b1;
    @(negedge clk); zeroize = 1'b0;
    check("R2", '0);

    // R4: write during a block is held, then replaces the chaining value.
    mode = 3'd1; enc = 1'b1;
    host_load(128'h1);
    blk_begin();
    host_load(128'h2222);
    check("R4 held", 128'h1);
    blk_end('0, 128'h3333);
    check("R4 landed", 128'h2222);

    // R4: write in the completion cycle wins.
    blk_begin();
    @(negedge clk); done = 1'b1; bres = 128'h4444; hwr = 1'b1; hdata = 128'h5555;
    @(negedge clk); done = 1'b0; hwr = 1'b0;
    check("R4 same cycle", 128'h5555);

    // R2: zeroize drops a held write; the chaining value then counts from zero.
    mode = 3'd3; csize = 3'd0;
    host_load(128'h7777);
    blk_begin();
    host_load(128'h9999);
    @(negedge clk); zeroize = 1'b1;
    @(negedge clk); zeroize = 1'b0;
    check("R2 zero", '0);
    blk_end('0, '0);
    check("R2 hold dropped", 128'h1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule